// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry-Out

This block is the combinational shifter that conditions the second operand of an ALU. It takes a 32-bit value, a shift kind, a shift amount and the current carry flag, and produces the shifted value together with the shifter carry-out. The carry-out is the last bit pushed off the end of the word. The five kinds are logical left, logical right, arithmetic right, rotate right, and a one-place rotate through the carry flag.

The amount comes from one of two sources. The first is a 5-bit immediate field, covering 0 to 31. The second is a full byte taken from a register, covering 0 to 255, so it can exceed the word width. Amounts of zero, exactly the word width, and above the word width each follow their own rule for the value and the carry. The block has no clock and no state. The result is valid in the same cycle as the inputs.

Top module: `barrel_shifter`

## Requirements
- R1: With kind code 0 (logical left) and an amount n from 1 to 31, the result is the value shifted left by n with zeros entering bit 0, and carry-out is input bit 32-n.
- R2: With kind code 1 (logical right) and n from 1 to 31, the result is the value shifted right by n with zeros entering the top, and carry-out is input bit n-1.
- R3: With kind code 2 (arithmetic right) and n from 1 to 31, the vacated top bits are filled with input bit 31, and carry-out is input bit n-1.
- R4: With kind code 3 (rotate right) and n from 1 to 31, bits leaving bit 0 re-enter at bit 31 in order, and carry-out equals result bit 31.
- R5: With kind code 4 (rotate through carry), the result is {carry_in, value[31:1]} and carry-out is value bit 0. The amount inputs have no effect.
- R6: An effective amount of 0, from either source, leaves both the value and the carry unchanged for kind codes 0 to 3.
- R7: For a register amount of exactly 32, logical left gives 0 with carry-out equal to value bit 0. Logical right gives 0 with carry-out equal to value bit 31.
- R8: For register amounts from 33 to 255, logical left and logical right both give 0 with carry-out 0.
- R9: For register amounts of 32 or more, arithmetic right fills every result bit and the carry-out with value bit 31.
- R10: For register amounts of 32 or more, rotate right uses the amount modulo 32. A nonzero multiple of 32 returns the value unchanged, with carry-out equal to value bit 31.
- R11: When amt_from_reg is 0, the 5-bit immediate is the amount and amt_reg is ignored. When it is 1, the full byte amt_reg is the amount and amt_imm is ignored.
- R12: Kind codes 5, 6 and 7 pass the value and the carry through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_value | input | 32 | Operand to be shifted |
| op_kind | input | 3 | Shift kind code (0 LSL, 1 LSR, 2 ASR, 3 ROR, 4 RRX) |
| amt_imm | input | 5 | Immediate shift amount |
| amt_reg | input | 8 | Register-sourced shift amount byte |
| amt_from_reg | input | 1 | 1 selects amt_reg, 0 selects amt_imm |
| carry_in | input | 1 | Current carry flag |
| res_value | output | 32 | Shifted operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The embedded checks run on every input change and cover the structural invariants. A left shift always clears bit 0 and a right logical shift always clears bit 31. Arithmetic right keeps the sign bit, and rotation keeps the population count. Each fill mask holds exactly as many ones as the shift leaves. Zero amounts pass the value and carry through, and oversize logical shifts give zero. Only the bench's scenarios can confirm the exact bit positions of each result and the choice of carry bit. The same holds for the modulo behaviour of large rotates and the ranges at 32 and above 32. For these, the bench compares against hand-worked vectors and an independent sweep of every register amount from 0 to 40.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

  typedef enum logic [2:0] {
    SK_LSL = 3'd0,
    SK_LSR = 3'd1,
    SK_ASR = 3'd2,
    SK_ROR = 3'd3,
    SK_RRX = 3'd4
  } shift_kind_e;

  typedef struct packed {
    logic is_zero;
    logic is_full;
    logic is_over;
  } amt_class_t;

endpackage

// File: rtl/bshift_amount.sv
module bshift_amount
  import bshift_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 5,
  parameter int SEL_W = 8
) (
  input  logic [IMM_W-1:0] amt_imm,
  input  logic [SEL_W-1:0] amt_reg,
  input  logic             from_reg,
  output logic [IMM_W-1:0] amt_low,
  output amt_class_t       amt_cls
);

  localparam logic [SEL_W-1:0] FULL_AMT = SEL_W'(W);

  logic [SEL_W-1:0] amt_eff;

  always_comb begin
    amt_eff         = from_reg ? amt_reg : SEL_W'(amt_imm);
    amt_low         = amt_eff[IMM_W-1:0];
    amt_cls.is_zero = (amt_eff == '0);
    amt_cls.is_full = (amt_eff == FULL_AMT);
    amt_cls.is_over = (amt_eff > FULL_AMT);
  end

  always_comb begin
    if (!from_reg) begin
      assert_imm_in_range_R11: assert (!amt_cls.is_full && !amt_cls.is_over)
        else $error("immediate amount classified out of range");
    end
  end

endmodule

// File: rtl/bshift_rotator.sv
module bshift_rotator #(
  parameter int W     = 32,
  parameter int IMM_W = 5
) (
  input  logic [W-1:0]     data_in,
  input  logic [IMM_W-1:0] rot_amt,
  output logic [W-1:0]     data_out
);

  logic [W-1:0] stage [IMM_W+1];

  assign stage[0] = data_in;

  for (genvar s = 0; s < IMM_W; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = rot_amt[s]
                      ? {stage[s][STEP-1:0], stage[s][W-1:STEP]}
                      : stage[s];
  end

  assign data_out = stage[IMM_W];

  always_comb begin
    assert_rot_keeps_ones_R4: assert ($countones(data_out) == $countones(data_in))
      else $error("rotator changed population count");
  end

endmodule

// File: rtl/bshift_mask.sv
module bshift_mask #(
  parameter int W     = 32,
  parameter int IMM_W = 5
) (
  input  logic [IMM_W-1:0] amt_low,
  output logic [W-1:0]     keep_low,
  output logic [W-1:0]     keep_high
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign keep_high[i]     = (IMM_W'(i) >= amt_low);
    assign keep_low[W-1-i]  = (IMM_W'(i) >= amt_low);
  end

  always_comb begin
    assert_mask_count_R2: assert ($countones(keep_low) == W - int'(amt_low))
      else $error("right-shift mask has wrong width");
    assert_mask_count_R1: assert ($countones(keep_high) == W - int'(amt_low))
      else $error("left-shift mask has wrong width");
  end

endmodule

// File: rtl/barrel_shifter.sv
module barrel_shifter
  import bshift_pkg::*;
#(
  parameter int W        = 32,
  parameter int AMT_BITS = 8,
  localparam int IMM_W   = $clog2(W)
) (
  input  logic [W-1:0]        op_value,
  input  logic [2:0]          op_kind,
  input  logic [IMM_W-1:0]    amt_imm,
  input  logic [AMT_BITS-1:0] amt_reg,
  input  logic                amt_from_reg,
  input  logic                carry_in,
  output logic [W-1:0]        res_value,
  output logic                carry_out
);

  shift_kind_e      kind;
  logic [IMM_W-1:0] amt_low;
  amt_class_t       amt_cls;
  logic [IMM_W-1:0] rot_amt;
  logic [W-1:0]     rotated;
  logic [W-1:0]     keep_low;
  logic [W-1:0]     keep_high;
  logic             sign_bit;

  assign kind     = shift_kind_e'(op_kind);
  assign sign_bit = op_value[W-1];
  assign rot_amt  = (kind == SK_LSL) ? (-amt_low) : amt_low;

  bshift_amount #(.W(W), .IMM_W(IMM_W), .SEL_W(AMT_BITS)) u_amount (
    .amt_imm (amt_imm),
    .amt_reg (amt_reg),
    .from_reg(amt_from_reg),
    .amt_low (amt_low),
    .amt_cls (amt_cls)
  );

  bshift_rotator #(.W(W), .IMM_W(IMM_W)) u_rotator (
    .data_in (op_value),
    .rot_amt (rot_amt),
    .data_out(rotated)
  );

  bshift_mask #(.W(W), .IMM_W(IMM_W)) u_mask (
    .amt_low  (amt_low),
    .keep_low (keep_low),
    .keep_high(keep_high)
  );

  always_comb begin
    res_value = op_value;
    carry_out = carry_in;
    unique case (kind)
      SK_LSL: begin
        if (amt_cls.is_zero) begin
          res_value = op_value;
          carry_out = carry_in;
        end else if (amt_cls.is_full) begin
          res_value = '0;
          carry_out = op_value[0];
        end else if (amt_cls.is_over) begin
          res_value = '0;
          carry_out = 1'b0;
        end else begin
          res_value = rotated & keep_high;
          carry_out = rotated[0];
        end
      end
      SK_LSR: begin
        if (amt_cls.is_zero) begin
          res_value = op_value;
          carry_out = carry_in;
        end else if (amt_cls.is_full) begin
          res_value = '0;
          carry_out = op_value[W-1];
        end else if (amt_cls.is_over) begin
          res_value = '0;
          carry_out = 1'b0;
        end else begin
          res_value = rotated & keep_low;
          carry_out = rotated[W-1];
        end
      end
      SK_ASR: begin
        if (amt_cls.is_zero) begin
          res_value = op_value;
          carry_out = carry_in;
        end else if (amt_cls.is_full || amt_cls.is_over) begin
          res_value = {W{sign_bit}};
          carry_out = sign_bit;
        end else begin
          res_value = (rotated & keep_low) | (~keep_low & {W{sign_bit}});
          carry_out = rotated[W-1];
        end
      end
      SK_ROR: begin
        if (amt_cls.is_zero) begin
          res_value = op_value;
          carry_out = carry_in;
        end else begin
          res_value = rotated;
          carry_out = rotated[W-1];
        end
      end
      SK_RRX: begin
        res_value = {carry_in, op_value[W-1:1]};
        carry_out = op_value[0];
      end
      default: begin
        res_value = op_value;
        carry_out = carry_in;
      end
    endcase
  end

  always_comb begin
    if (kind == SK_LSL && !amt_cls.is_zero) begin
      assert_lsl_clears_lsb_R1: assert (res_value[0] == 1'b0)
        else $error("left shift left bit 0 set");
    end
    if (kind == SK_LSR && !amt_cls.is_zero) begin
      assert_lsr_clears_msb_R2: assert (res_value[W-1] == 1'b0)
        else $error("logical right shift left top bit set");
    end
    if (kind == SK_ASR) begin
      assert_asr_keeps_sign_R3: assert (res_value[W-1] == op_value[W-1])
        else $error("arithmetic shift lost sign");
    end
    if (kind == SK_ROR) begin
      assert_ror_keeps_ones_R4: assert ($countones(res_value) == $countones(op_value))
        else $error("rotate changed population count");
    end
    if (kind == SK_RRX) begin
      assert_rrx_shape_R5: assert (res_value[W-1] == carry_in && carry_out == op_value[0])
        else $error("rotate through carry misplaced carry");
    end
    if (amt_cls.is_zero && kind != SK_RRX) begin
      assert_zero_amt_identity_R6: assert (res_value == op_value && carry_out == carry_in)
        else $error("zero amount altered operand or carry");
    end
    if ((kind == SK_LSL || kind == SK_LSR) && amt_cls.is_over) begin
      assert_oversize_clears_R8: assert (res_value == '0 && carry_out == 1'b0)
        else $error("oversize logical shift not cleared");
    end
    if (kind == SK_ASR && (amt_cls.is_full || amt_cls.is_over)) begin
      assert_asr_big_fill_R9: assert ($countones(res_value) == (sign_bit ? W : 0) && carry_out == sign_bit)
        else $error("large arithmetic shift not sign filled");
    end
  end

endmodule

// File: tb/barrel_shifter_tb.sv
module barrel_shifter_tb;

  localparam int W = 32;

  logic          clk;
  logic [W-1:0]  op_value;
  logic [2:0]    op_kind;
  logic [4:0]    amt_imm;
  logic [7:0]    amt_reg;
  logic          amt_from_reg;
  logic          carry_in;
  logic [W-1:0]  res_value;
  logic          carry_out;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  barrel_shifter u_dut (
    .op_value    (op_value),
    .op_kind     (op_kind),
    .amt_imm     (amt_imm),
    .amt_reg     (amt_reg),
    .amt_from_reg(amt_from_reg),
    .carry_in    (carry_in),
    .res_value   (res_value),
    .carry_out   (carry_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [2:0]  kind;
    logic        from_reg;
    logic [4:0]  imm;
    logic [7:0]  areg;
    logic        cin;
    logic [31:0] val;
    logic [31:0] eres;
    logic        ec;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b0, 5'd4,  8'd0,   1'b0, 32'h1000_0001, 32'h0000_0010, 1'b1, 4'd1},  // R1
    '{3'd0, 1'b0, 5'd1,  8'd0,   1'b1, 32'h7FFF_FFFF, 32'hFFFF_FFFE, 1'b0, 4'd1},  // R1
    '{3'd1, 1'b0, 5'd8,  8'd0,   1'b0, 32'h1234_5680, 32'h0012_3456, 1'b1, 4'd2},  // R2
    '{3'd1, 1'b0, 5'd31, 8'd0,   1'b1, 32'h8000_0000, 32'h0000_0001, 1'b0, 4'd2},  // R2
    '{3'd2, 1'b0, 5'd4,  8'd0,   1'b0, 32'hF000_0018, 32'hFF00_0001, 1'b1, 4'd3},  // R3
    '{3'd2, 1'b0, 5'd4,  8'd0,   1'b0, 32'h7000_0018, 32'h0700_0001, 1'b1, 4'd3},  // R3
    '{3'd3, 1'b0, 5'd8,  8'd0,   1'b1, 32'h1234_5678, 32'h7812_3456, 1'b0, 4'd4},  // R4
    '{3'd3, 1'b0, 5'd4,  8'd0,   1'b0, 32'h0000_000F, 32'hF000_0000, 1'b1, 4'd4},  // R4
    '{3'd4, 1'b0, 5'd7,  8'd0,   1'b1, 32'h0000_0003, 32'h8000_0001, 1'b1, 4'd5},  // R5
    '{3'd4, 1'b1, 5'd0,  8'd5,   1'b0, 32'h8000_0002, 32'h4000_0001, 1'b0, 4'd5},  // R5
    '{3'd0, 1'b0, 5'd0,  8'd0,   1'b1, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b1, 4'd6},  // R6
    '{3'd1, 1'b1, 5'd9,  8'd0,   1'b1, 32'h0000_1234, 32'h0000_1234, 1'b1, 4'd6},  // R6
    '{3'd2, 1'b1, 5'd0,  8'd0,   1'b0, 32'h8000_0000, 32'h8000_0000, 1'b0, 4'd6},  // R6
    '{3'd0, 1'b1, 5'd0,  8'd32,  1'b0, 32'h0000_0001, 32'h0000_0000, 1'b1, 4'd7},  // R7
    '{3'd1, 1'b1, 5'd0,  8'd32,  1'b0, 32'h8000_0000, 32'h0000_0000, 1'b1, 4'd7},  // R7
    '{3'd0, 1'b1, 5'd0,  8'd33,  1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 4'd8},  // R8
    '{3'd1, 1'b1, 5'd0,  8'd200, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 4'd8},  // R8
    '{3'd2, 1'b1, 5'd0,  8'd32,  1'b0, 32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 4'd9},  // R9
    '{3'd2, 1'b1, 5'd0,  8'd255, 1'b1, 32'h7FFF_FFFF, 32'h0000_0000, 1'b0, 4'd9},  // R9
    '{3'd3, 1'b1, 5'd0,  8'd64,  1'b0, 32'h8000_0001, 32'h8000_0001, 1'b1, 4'd10}, // R10
    '{3'd3, 1'b1, 5'd0,  8'd36,  1'b0, 32'h0000_000F, 32'hF000_0000, 1'b1, 4'd10}, // R10
    '{3'd0, 1'b1, 5'd9,  8'd4,   1'b0, 32'h0000_0001, 32'h0000_0010, 1'b0, 4'd11}, // R11
    '{3'd1, 1'b0, 5'd2,  8'd8,   1'b1, 32'h0000_0010, 32'h0000_0004, 1'b0, 4'd11}, // R11
    '{3'd5, 1'b0, 5'd3,  8'd0,   1'b1, 32'h0000_0055, 32'h0000_0055, 1'b1, 4'd12}  // R12
  };

  function automatic logic [32:0] ref_shift(input logic [2:0] k, input int n,
                                            input logic [31:0] v, input logic c);
    logic [31:0] r;
    int m;
    case (k)
      3'd0: if (n == 0) return {v, c};
            else if (n < 32) return {v << n, v[32-n]};
            else if (n == 32) return {32'd0, v[0]};
            else return 33'd0;
      3'd1: if (n == 0) return {v, c};
            else if (n < 32) return {v >> n, v[n-1]};
            else if (n == 32) return {32'd0, v[31]};
            else return 33'd0;
      3'd2: if (n == 0) return {v, c};
            else if (n < 32) return {32'($signed(v) >>> n), v[n-1]};
            else return {{32{v[31]}}, v[31]};
      3'd3: begin
        if (n == 0) return {v, c};
        m = n % 32;
        if (m == 0) return {v, v[31]};
        r = (v >> m) | (v << (32 - m));
        return {r, r[31]};
      end
      3'd4: return {c, v[31:1], v[0]};
      default: return {v, c};
    endcase
  endfunction

  task automatic apply(input logic [2:0] k, input logic fr, input logic [4:0] im,
                       input logic [7:0] ar, input logic c, input logic [31:0] v);
    @(posedge clk);
    op_kind = k; amt_from_reg = fr; amt_imm = im; amt_reg = ar;
    carry_in = c; op_value = v;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] er, input logic ec);
    n_checks++;
    if (res_value !== er || carry_out !== ec) begin
      n_fail++;
      $display("FAIL %s: kind=%0d amt_imm=%0d amt_reg=%0d sel=%0b value=%h cin=%0b got %h/%0b expected %h/%0b",
               tag, op_kind, amt_imm, amt_reg, amt_from_reg, op_value, carry_in,
               res_value, carry_out, er, ec);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    op_kind = 3'd0; amt_from_reg = 1'b0; amt_imm = 5'd0; amt_reg = 8'd0;
    carry_in = 1'b0; op_value = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R6 idle inputs", 32'd0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].kind, VECS[i].from_reg, VECS[i].imm, VECS[i].areg,
            VECS[i].cin, VECS[i].val);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].eres, VECS[i].ec);
    end

    // R11: immediate ignored when register selected, and vice versa
    apply(3'd1, 1'b1, 5'd31, 8'd1, 1'b0, 32'h0000_0006);
    check("R11 reg source", 32'h0000_0003, 1'b0);
    apply(3'd1, 1'b0, 5'd1, 8'd40, 1'b0, 32'h0000_0006);
    check("R11 imm source", 32'h0000_0003, 1'b0);

    // R12: remaining unused codes
    apply(3'd6, 1'b1, 5'd0, 8'd7, 1'b0, 32'hCAFE_F00D);
    check("R12 code 6", 32'hCAFE_F00D, 1'b0);
    apply(3'd7, 1'b0, 5'd17, 8'd0, 1'b1, 32'h0F0F_0F0F);
    check("R12 code 7", 32'h0F0F_0F0F, 1'b1);

    // R5: amount has no effect on rotate through carry
    apply(3'd4, 1'b1, 5'd0, 8'd255, 1'b0, 32'hFFFF_FFFF);
    check("R5 large amount", 32'h7FFF_FFFF, 1'b1);

    // Sweep register amounts 0..40 for R1 R2 R3 R4 R6 R7 R8 R9 R10
    for (int k = 0; k < 4; k++) begin
      for (int n = 0; n <= 40; n++) begin
        for (int s = 0; s < 2; s++) begin
          for (int c = 0; c < 2; c++) begin
            logic [31:0] v;
            logic [32:0] e;
            v = (s == 0) ? 32'h8000_0001 : 32'h6B3C_91E5;
            e = ref_shift(3'(k), n, v, 1'(c));
            apply(3'(k), 1'b1, 5'd0, 8'(n), 1'(c), v);
            check($sformatf("R%0d sweep amt %0d", (n == 0) ? 6 : (n < 32 ? k + 1 : 7 + k), n),
                  e[32:1], e[0]);
          end
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule